// File: doc/BRIEF.md
# Ping-pong DMA channel

This block is one peripheral DMA channel with two buffer slots, A and B, each holding a start address and a byte count. Software fills a slot and marks it started. On each request from the peripheral, the channel moves one burst of 8-bit or 16-bit units between the peripheral and a word-wide memory port. The slot in use advances as the burst proceeds. When the slot's count runs out, the hardware records that slot as done and, if the other slot is already started, switches to the other slot without software help. The driver can refill the finished slot while the other slot is being drained, so a stream runs without gaps.

The channel's control and status share one 8-bit register. Software sets bits by writing ones to one address and clears bits by writing ones to a second address. It reads the register back at a third address. A read of a slot's start register returns the current transfer position. An interrupt line reports finished slots and address faults.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset the status register, the configuration register and all slot registers read zero, irq is low and no memory access is made.
- R2: Status bits are run=0, irq enable=1, error=2, done A=3, started A=4, done B=5, started B=6 and active slot=7 (0 = A, 1 = B). Writing ones to offset 0x04 sets those bits and writing ones to offset 0x08 clears them. Zero bits leave their state unchanged. Offset 0x0C reads the status.
- R3: Slot registers are start A at 0x10, count A at 0x14, start B at 0x18 and count B at 0x1C. The two low bits of a start address are stored as zero. A count holds 13 bits, so the largest value is 0x1FFF.
- R4: The configuration register at 0x00 uses bit0 for direction (1 = peripheral to memory, which writes memory; 0 = memory to peripheral, which reads it), bit1 to swap the two bytes of a 16-bit unit, bit2 for burst length (1 = 8 units, 0 = 4 units) and bit3 for unit width (1 = 16-bit, 0 = 8-bit). An 8-bit unit at address a uses byte lane a[1:0] with byte enable 1<<a[1:0] and write data replicated in all four lanes. A 16-bit unit uses the lower half when a[1]=0 and the upper half when a[1]=1, with byte enables 0011 or 1100 and the unit replicated in both halves.
- R5: When run is set, the active slot is started and its count is non-zero, a peripheral request starts a burst. The burst moves one unit per cycle until it reaches the burst length or the slot's end. Each unit advances the slot's start by the unit width and lowers its count by the same amount, stopping at zero. dev_ack pulses in the cycle of the burst's last unit.
- R6: When the active slot's count reaches zero, its done bit sets, its started bit clears and the burst ends. The active-slot bit moves to the other slot only if that slot is started.
- R7: irq is high exactly when irq enable is set and at least one of error, done A or done B is set.
- R8: While run is clear, no memory access is made and slot state is kept. Setting run again lets the next request continue from the saved position.
- R9: A unit whose address is at or above MEM_BYTES, or is odd in 16-bit mode, is not performed. Instead the error bit sets and run clears.
- R10: A done or error bit that hardware sets in the same cycle as a software clear of that bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dev_req | input | 1 | Peripheral burst request |
| dev_din | input | 16 | Unit from peripheral (peripheral to memory) |
| dev_dout | output | 16 | Unit to peripheral (memory to peripheral) |
| dev_dstb | output | 1 | dev_dout is valid this cycle |
| dev_ack | output | 1 | Last unit of a burst |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Byte address of the unit |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| irq | output | 1 | Interrupt |

## Verification
Two things can land on the same clock edge. One is the hardware finishing a slot and setting its done bit. The other is software writing that done bit to the clear address. The bench makes them coincide by timing the request of a one-byte transfer so that the clear write is sampled on the edge that moves the single unit. It then expects the done bit still set, and expects a later clear alone to remove it. A second overlap comes from the automatic switch to the other slot: the bench drains slot A while slot B is already started and checks the active-slot bit and both done bits against the expected values.

// File: rtl/pp_dma_pkg.sv
`timescale 1ns/1ps
package pp_dma_pkg;
  localparam int ST_RUN   = 0;
  localparam int ST_IE    = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_DONEA = 3;
  localparam int ST_STRTA = 4;
  localparam int ST_DONEB = 5;
  localparam int ST_STRTB = 6;
  localparam int ST_BIU   = 7;

  localparam int CF_DIR   = 0;
  localparam int CF_SWAP  = 1;
  localparam int CF_BURST = 2;
  localparam int CF_WIDE  = 3;

  function automatic logic [1:0] unit_bytes(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [3:0] burst_units(input logic b8);
    return b8 ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] a, input logic wide);
    if (wide) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << a;
  endfunction

  function automatic logic [31:0] pack_unit(input logic [15:0] d, input logic wide,
                                            input logic swap);
    logic [15:0] u;
    u = swap ? {d[7:0], d[15:8]} : d;
    return wide ? {u, u} : {4{d[7:0]}};
  endfunction

  function automatic logic [15:0] pick_unit(input logic [31:0] w, input logic [1:0] a,
                                            input logic wide, input logic swap);
    logic [15:0] h;
    h = a[1] ? w[31:16] : w[15:0];
    if (wide) return swap ? {h[7:0], h[15:8]} : h;
    return {8'h00, w[{a, 3'b000} +: 8]};
  endfunction

  function automatic logic addr_ok(input logic [31:0] a, input logic wide,
                                   input logic [31:0] limit);
    return (a < limit) && !(wide && a[0]);
  endfunction
endpackage

// File: rtl/pp_dma_slot.sv
`timescale 1ns/1ps
module pp_dma_slot #(
  parameter int AW = 32,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_count,
  input  logic [AW-1:0] start_in,
  input  logic [CW-1:0] count_in,
  input  logic          adv,
  input  logic [1:0]    step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] step_w;
  assign step_w = {{(CW-2){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else if (adv) begin
      addr <= addr + {{(AW-2){1'b0}}, step};
      cnt  <= (cnt > step_w) ? cnt - step_w : '0;
    end else begin
      if (wr_start) addr <= start_in;
      if (wr_count) cnt  <= count_in;
    end
  end

  assert_count_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt < $past(cnt)));
endmodule

// File: rtl/pp_dma_engine.sv
`timescale 1ns/1ps
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 13,
  parameter int MEM_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          strt,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] cur_cnt,
  input  logic [3:0]    cfg,
  input  logic          dev_req,
  input  logic [15:0]   dev_din,
  input  logic [31:0]   mem_rdata,
  output logic          unit_adv,
  output logic          slot_end,
  output logic          fault,
  output logic [1:0]    step,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic [15:0]   dev_dout,
  output logic          dev_dstb,
  output logic          dev_ack
);
  logic       busy;
  logic [3:0] beat;
  logic       go, ok, last_unit, burst_done, wide;

  assign wide       = cfg[CF_WIDE];
  assign step       = unit_bytes(wide);
  assign go         = busy && run && strt && (cur_cnt != '0);
  assign ok         = addr_ok(32'(cur_addr), wide, 32'(MEM_BYTES));
  assign fault      = go && !ok;
  assign unit_adv   = go && ok;
  assign last_unit  = cur_cnt <= {{(CW-2){1'b0}}, step};
  assign slot_end   = unit_adv && last_unit;
  assign burst_done = unit_adv && (last_unit || beat == burst_units(cfg[CF_BURST]) - 4'd1);
  assign dev_ack    = burst_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (!busy) begin
      busy <= run && strt && dev_req && (cur_cnt != '0);
      beat <= '0;
    end else if (!go || fault || burst_done) begin
      busy <= 1'b0;
    end else begin
      beat <= beat + 4'd1;
    end
  end

  assign mem_en    = unit_adv;
  assign mem_we    = unit_adv && cfg[CF_DIR];
  assign mem_addr  = cur_addr;
  assign mem_be    = unit_adv ? lane_be(cur_addr[1:0], wide) : 4'b0000;
  assign mem_wdata = pack_unit(dev_din, wide, cfg[CF_SWAP]);
  assign dev_dout  = pick_unit(mem_rdata, cur_addr[1:0], wide, cfg[CF_SWAP]);
  assign dev_dstb  = unit_adv && !cfg[CF_DIR];

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> !dev_ack);
endmodule

// File: rtl/pp_dma_chan.sv
`timescale 1ns/1ps
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 13,
  parameter int MEM_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dev_req,
  input  logic [15:0]   dev_din,
  output logic [15:0]   dev_dout,
  output logic          dev_dstb,
  output logic          dev_ack,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int NSLOT = 2;

  logic [31:0]   cfg;
  logic [7:0]    status, st_sw, st_nx;
  logic [AW-1:0] slot_addr [NSLOT];
  logic [CW-1:0] slot_cnt  [NSLOT];
  logic          act, cur_strt, unit_adv, slot_end, fault;
  logic [1:0]    step;
  logic          sel_set, sel_clr;

  assign act      = status[ST_BIU];
  assign cur_strt = act ? status[ST_STRTB] : status[ST_STRTA];
  assign sel_set  = reg_we && reg_addr == 5'h04;
  assign sel_clr  = reg_we && reg_addr == 5'h08;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pp_dma_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_start (reg_we && reg_addr == 5'(16 + 8 * s)),
      .wr_count (reg_we && reg_addr == 5'(20 + 8 * s)),
      .start_in ({reg_wdata[AW-1:2], 2'b00}),
      .count_in (reg_wdata[CW-1:0]),
      .adv      (unit_adv && (act == 1'(s))),
      .step     (step),
      .addr     (slot_addr[s]),
      .cnt      (slot_cnt[s])
    );
  end

  pp_dma_engine #(.AW(AW), .CW(CW), .MEM_BYTES(MEM_BYTES)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (status[ST_RUN]),
    .strt      (cur_strt),
    .cur_addr  (slot_addr[act]),
    .cur_cnt   (slot_cnt[act]),
    .cfg       (cfg[3:0]),
    .dev_req   (dev_req),
    .dev_din   (dev_din),
    .mem_rdata (mem_rdata),
    .unit_adv  (unit_adv),
    .slot_end  (slot_end),
    .fault     (fault),
    .step      (step),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .dev_dout  (dev_dout),
    .dev_dstb  (dev_dstb),
    .dev_ack   (dev_ack)
  );

  // Software first, hardware events on top: hardware wins a same-cycle conflict.
  always_comb begin
    st_sw = status;
    if (sel_set) st_sw = st_sw | reg_wdata[7:0];
    if (sel_clr) st_sw = st_sw & ~reg_wdata[7:0];
    st_nx = st_sw;
    if (slot_end) begin
      if (act) begin
        st_nx[ST_DONEB] = 1'b1;
        st_nx[ST_STRTB] = 1'b0;
        if (st_sw[ST_STRTA]) st_nx[ST_BIU] = 1'b0;
      end else begin
        st_nx[ST_DONEA] = 1'b1;
        st_nx[ST_STRTA] = 1'b0;
        if (st_sw[ST_STRTB]) st_nx[ST_BIU] = 1'b1;
      end
    end
    if (fault) begin
      st_nx[ST_ERR] = 1'b1;
      st_nx[ST_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      cfg    <= '0;
    end else begin
      status <= st_nx;
      if (reg_we && reg_addr == 5'h00) cfg <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = cfg;
      5'h0C:   reg_rdata = {24'h0, status};
      5'h10:   reg_rdata = 32'(slot_addr[0]);
      5'h14:   reg_rdata = 32'(slot_cnt[0]);
      5'h18:   reg_rdata = 32'(slot_addr[1]);
      5'h1C:   reg_rdata = 32'(slot_cnt[1]);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = status[ST_IE] &&
               (status[ST_ERR] || status[ST_DONEA] || status[ST_DONEB]);

  assert_fault_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (status[ST_ERR] && !status[ST_RUN]));

  assert_end_marks_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !act) |=> (status[ST_DONEA] && !status[ST_STRTA]));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_DONEA] && !(sel_clr && reg_wdata[ST_DONEA])) |=> status[ST_DONEA]);
endmodule

// File: tb/sim_pp_dma_chan.sv
`timescale 1ns/1ps
module sim_pp_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_req = 1'b0;
  logic [15:0] dev_din = '0;
  logic [15:0] dev_dout;
  logic        dev_dstb, dev_ack, mem_en, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] q_addr[$];
  logic [3:0]  q_be[$];
  logic [31:0] q_data[$];
  logic [15:0] q_rd[$];

  always #2 clk = ~clk;

  pp_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_din(dev_din), .dev_dout(dev_dout), .dev_dstb(dev_dstb),
    .dev_ack(dev_ack), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk)
    if (mem_en && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected memory writes and peripheral reads.
  task automatic exp_wr8(input logic [31:0] a, input logic [7:0] d);
    q_addr.push_back(a); q_be.push_back(4'b0001 << a[1:0]); q_data.push_back({4{d}});
  endtask
  task automatic exp_rd(input logic [15:0] d);
    q_rd.push_back(d);
  endtask

  // Monitor side: compare every access the design makes.
  always @(negedge clk) begin
    if (rst_n && mem_en && mem_we) begin
      if (q_addr.size() == 0) chk("R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        chk("R5 write addr", mem_addr, q_addr.pop_front());
        chk("R4 write be", {28'h0, mem_be}, {28'h0, q_be.pop_front()});
        chk("R4 write data", mem_wdata, q_data.pop_front());
      end
    end else if (rst_n && mem_en) begin
      if (q_rd.size() == 0) chk("R8 unexpected read", {16'h0, dev_dout}, 32'hFFFF_FFFF);
      else chk("R4 read unit", {16'h0, dev_dout}, {16'h0, q_rd.pop_front()});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask
  task automatic req(input logic [15:0] d);
    @(negedge clk); dev_req = 1'b1; dev_din = d;
    @(negedge clk); dev_req = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 mem_en", {31'h0, mem_en}, 32'h0);
    rchk("R1 status", 5'h0C, 32'h0);
    rchk("R1 cfg", 5'h00, 32'h0);
    rchk("R1 startA", 5'h10, 32'h0);
    rchk("R1 countB", 5'h1C, 32'h0);
    rst_n = 1'b1;

    // R2 set / clear semantics
    wr(5'h04, 32'h42); rchk("R2 set", 5'h0C, 32'h42);
    wr(5'h04, 32'h00); rchk("R2 zero set", 5'h0C, 32'h42);
    wr(5'h08, 32'h40); rchk("R2 clear", 5'h0C, 32'h02);
    wr(5'h08, 32'h02); rchk("R2 clear all", 5'h0C, 32'h00);

    // R3 slot register masking
    wr(5'h10, 32'h107);  rchk("R3 start align", 5'h10, 32'h104);
    wr(5'h14, 32'hFFFF); rchk("R3 count width", 5'h14, 32'h1FFF);

    // R5 R6 R7: peripheral to memory, 8-bit, burst 4, six bytes
    wr(5'h00, 32'h1); wr(5'h10, 32'h100); wr(5'h14, 32'd6);
    wr(5'h04, 32'h13);
    for (int i = 0; i < 4; i++) exp_wr8(32'h100 + i, 8'hA5);
    req(16'h00A5);
    rchk("R5 position", 5'h10, 32'h104);
    rchk("R5 count", 5'h14, 32'd2);
    rchk("R5 status mid", 5'h0C, 32'h13);
    chk("R7 irq low", {31'h0, irq}, 32'h0);
    exp_wr8(32'h104, 8'h5A); exp_wr8(32'h105, 8'h5A);
    req(16'h005A);
    rchk("R6 done A no switch", 5'h0C, 32'h0B);
    rchk("R5 count zero", 5'h14, 32'd0);
    chk("R7 irq high", {31'h0, irq}, 32'h1);
    wr(5'h08, 32'h08);
    chk("R7 irq acked", {31'h0, irq}, 32'h0);
    wr(5'h08, 32'hFF);

    // R4 R6: memory to peripheral, 16-bit, swapped, burst 8, ping-pong A then B
    mem[32'h200 >> 2] = 32'h1122_3344;
    mem[32'h300 >> 2] = 32'h5566_7788;
    wr(5'h00, 32'hE);
    wr(5'h10, 32'h200); wr(5'h14, 32'd4);
    wr(5'h18, 32'h300); wr(5'h1C, 32'd4);
    wr(5'h04, 32'h53);
    exp_rd(16'h4433); exp_rd(16'h2211);
    req(16'h0);
    rchk("R6 switch to B", 5'h0C, 32'hCB);
    exp_rd(16'h8877); exp_rd(16'h6655);
    req(16'h0);
    rchk("R6 B done stays on B", 5'h0C, 32'hAB);
    rchk("R5 B position", 5'h18, 32'h304);
    wr(5'h08, 32'hFF);

    // R8 pause and resume
    wr(5'h00, 32'h1); wr(5'h10, 32'h400); wr(5'h14, 32'd8);
    wr(5'h04, 32'h11);
    wr(5'h08, 32'h01);
    req(16'h0077);
    rchk("R8 count kept", 5'h14, 32'd8);
    rchk("R8 position kept", 5'h10, 32'h400);
    rchk("R8 paused status", 5'h0C, 32'h10);
    wr(5'h04, 32'h01);
    for (int i = 0; i < 4; i++) exp_wr8(32'h400 + i, 8'h33);
    req(16'h0033);
    rchk("R8 resumed count", 5'h14, 32'd4);
    wr(5'h08, 32'hFF);

    // R9 out-of-range address
    wr(5'h10, 32'h1000); wr(5'h14, 32'd4);
    wr(5'h04, 32'h13);
    req(16'h0011);
    rchk("R9 error status", 5'h0C, 32'h16);
    rchk("R9 count unchanged", 5'h14, 32'd4);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    wr(5'h08, 32'hFF);

    // R10 hardware done coincides with software clear of done A
    wr(5'h10, 32'h600); wr(5'h14, 32'd1);
    wr(5'h04, 32'h13);
    exp_wr8(32'h600, 8'h99);
    @(negedge clk); dev_req = 1'b1; dev_din = 16'h0099;
    @(negedge clk); dev_req = 1'b0; reg_we = 1'b1; reg_addr = 5'h08; reg_wdata = 32'h08;
    @(negedge clk); reg_we = 1'b0;
    rchk("R10 done survives clear", 5'h0C, 32'h0B);
    wr(5'h08, 32'h08);
    rchk("R10 later clear", 5'h0C, 32'h03);

    repeat (4) @(negedge clk);
    chk("R5 write queue drained", q_addr.size(), 32'd0);
    chk("R4 read queue drained", q_rd.size(), 32'd0);
    finish_run();
  end
endmodule